// File: doc/BRIEF.md
# Two-Phase Interleaved Boost PWM Generator

This block drives the gates of two boost stages that run in parallel on one shared switching period. A single period counter sets the switching rate. Phase 1 starts its on-time at the top of the counter. Phase 2 starts its on-time exactly half a period later, so the ripple currents of the two stages partly cancel. The default period is 400 clock cycles, which gives 100 kHz from a 40 MHz clock.

Both on-times come from one main duty command and one signed balance correction, each in Q15. Phase 1 uses the main duty plus the correction. Phase 2 uses the main duty minus the correction. A negative result becomes zero, and any on-time is capped at 90 % of the period, so each stage always has at least 10 % off-time. Each phase takes its new on-time only at its own period start, so a pulse that is already running is never cut short or stretched by a new command.

A fault input blanks both gate outputs while it is present, and the counter keeps running so the stages resume in step when the fault clears. A low enable stops switching and holds the counter at its start. A one-cycle strobe marks every phase-1 period start and can be used to time sampling and the control loop.

Top module: `dual_phase_pwm`

## Requirements
- R1: The period counter wraps every PERIOD_CYC cycles (400 by default) while enabled. `periodStrobe` is high for exactly one cycle in each period, in the same cycle that a phase-1 pulse begins.
- R2: The phase-1 on-time comes from the sum mainDuty + balanceCorr, both read as signed 16-bit Q15. The pulse is one contiguous run of high cycles that starts on the strobe cycle.
- R3: The phase-2 on-time comes from mainDuty − balanceCorr. Its pulse is one contiguous run that starts PERIOD_CYC/2 cycles after the strobe.
- R4: A duty value d gives floor(d·PERIOD_CYC/32768) on-cycles. A negative d gives zero on-cycles, so that output stays low for the whole period.
- R5: No on-time exceeds floor(PERIOD_CYC·90/100) cycles (360 by default). Larger values are clamped to that limit.
- R6: Each phase latches its on-time only at its own period start. A change of mainDuty or balanceCorr in mid-period does not alter a pulse that is already in progress.
- R7: One cycle after faultIn is sampled high, both outputs are low, and they stay low while the fault lasts. The counter and the strobe keep running. One cycle after faultIn is sampled low again, the outputs follow the counter once more.
- R8: While enable is low, both outputs and the strobe are low, the counter is held at its start, and both latched on-times are cleared. At the first clock edge with enable high, the strobe and the phase-1 pulse appear. Phase 2 stays low until its own first period start, PERIOD_CYC/2 cycles later.
- R9: During reset, both outputs and the strobe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run switching when high |
| faultIn | input | 1 | Blank both gate outputs when high |
| mainDuty | input | 16 | Main duty command, signed Q15 |
| balanceCorr | input | 16 | Balance correction, signed Q15 |
| pwmPh1 | output | 1 | Phase-1 gate drive |
| pwmPh2 | output | 1 | Phase-2 gate drive, half a period behind phase 1 |
| periodStrobe | output | 1 | One-cycle pulse at each phase-1 period start |

## Verification
Every output is a register. A clock edge that samples counter position k therefore shows its result in the half-cycle right after that edge. The bench samples on falling edges and numbers each sample by its offset k from the strobe sample.

With that numbering:
- The phase-1 pulse is due over samples 0 to on1−1.
- The phase-2 pulse is due from sample PERIOD_CYC/2 onward. It is counted over the window from PERIOD_CYC/2 to 3·PERIOD_CYC/2−1, which holds exactly one latched phase-2 duty.
- Fault blanking and recovery are checked one sample after the edge that sampled the change.
- A command changed in mid-period is expected to show only in the count of the following period.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int DUTY_W = 16;
  localparam int NUM_PH = 2;

  typedef struct packed {
    logic              run;
    logic [NUM_PH-1:0] start;
  } pwm_tick_t;
endpackage

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import dual_pwm_pkg::*;
#(
  parameter int PERIOD_CYC = 400
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  output pwm_tick_t                     tick,
  output logic [NUM_PH-1:0][CNT_W-1:0]  posPh,
  output logic                          periodStrobe
);
  localparam int LAST = PERIOD_CYC - 1;

  logic [CNT_W-1:0]  cnt;
  logic [NUM_PH-1:0] startVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (!enable)              cnt <= '0;
    else if (cnt == CNT_W'(LAST))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : gPhase
    localparam int OFF = g * PERIOD_CYC / NUM_PH;
    assign startVec[g] = enable && (cnt == CNT_W'(OFF));
    if (OFF == 0) begin : gZero
      assign posPh[g] = cnt;
    end else begin : gShift
      assign posPh[g] = (cnt >= CNT_W'(OFF)) ? cnt - CNT_W'(OFF)
                                             : cnt + CNT_W'(PERIOD_CYC - OFF);
    end
  end

  assign tick.run   = enable;
  assign tick.start = startVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periodStrobe <= 1'b0;
    else       periodStrobe <= startVec[0];
  end
endmodule

// File: rtl/dual_pwm_dp.sv
module dual_pwm_dp
  import dual_pwm_pkg::*;
#(
  parameter int PERIOD_CYC = 400,
  parameter int MAX_PCT    = 90
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          faultIn,
  input  pwm_tick_t                     tick,
  input  logic [NUM_PH-1:0][CNT_W-1:0]  posPh,
  input  logic [DUTY_W-1:0]             mainDuty,
  input  logic [DUTY_W-1:0]             balanceCorr,
  output logic [NUM_PH-1:0]             pwmOut
);
  localparam int ON_MAX = PERIOD_CYC * MAX_PCT / 100;
  localparam int OW     = CNT_W + 1;
  localparam int PW     = DUTY_W - 1 + OW;

  logic signed [DUTY_W:0] mainExt;
  logic signed [DUTY_W:0] corrExt;

  assign mainExt = $signed({mainDuty[DUTY_W-1], mainDuty});
  assign corrExt = $signed({balanceCorr[DUTY_W-1], balanceCorr});

  for (genvar g = 0; g < NUM_PH; g++) begin : gPh
    localparam bit ADD_CORR = (g % 2) == 0;

    logic signed [DUTY_W:0] sumD;
    logic [DUTY_W-1:0]      posDuty;
    logic [PW-1:0]          prod;
    logic [PW-1:0]          onShift;
    logic [CNT_W-1:0]       onNew;
    logic [CNT_W-1:0]       onReg;
    logic [CNT_W-1:0]       onEff;
    logic                   pwmQ;

    if (ADD_CORR) begin : gAdd
      assign sumD = mainExt + corrExt;
    end else begin : gSub
      assign sumD = mainExt - corrExt;
    end

    assign posDuty = sumD[DUTY_W] ? '0 : sumD[DUTY_W-1:0];
    assign prod    = PW'(posDuty) * PW'(PERIOD_CYC);
    assign onShift = prod >> (DUTY_W - 1);
    assign onNew   = (onShift > PW'(ON_MAX)) ? CNT_W'(ON_MAX) : onShift[CNT_W-1:0];
    assign onEff   = tick.start[g] ? onNew : onReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              onReg <= '0;
      else if (!tick.run)     onReg <= '0;
      else if (tick.start[g]) onReg <= onNew;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwmQ <= 1'b0;
      else       pwmQ <= tick.run && !faultIn && (posPh[g] < onEff);
    end

    assign pwmOut[g] = pwmQ;
  end
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dual_pwm_pkg::*;
#(
  parameter int PERIOD_CYC = 400,
  parameter int MAX_PCT    = 90
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        faultIn,
  input  logic [15:0] mainDuty,
  input  logic [15:0] balanceCorr,
  output logic        pwmPh1,
  output logic        pwmPh2,
  output logic        periodStrobe
);
  pwm_tick_t                    tick;
  logic [NUM_PH-1:0][CNT_W-1:0] posPh;
  logic [NUM_PH-1:0]            pwmVec;

  dual_pwm_ctrl #(.PERIOD_CYC(PERIOD_CYC)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .tick         (tick),
    .posPh        (posPh),
    .periodStrobe (periodStrobe)
  );

  dual_pwm_dp #(.PERIOD_CYC(PERIOD_CYC), .MAX_PCT(MAX_PCT)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .faultIn     (faultIn),
    .tick        (tick),
    .posPh       (posPh),
    .mainDuty    (mainDuty),
    .balanceCorr (balanceCorr),
    .pwmOut      (pwmVec)
  );

  assign pwmPh1 = pwmVec[0];
  assign pwmPh2 = pwmVec[1];
endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk #(
  parameter int PERIOD_CYC = 400,
  parameter int MAX_PCT    = 90
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic faultIn,
  input logic pwmPh1,
  input logic pwmPh2,
  input logic periodStrobe
);
  localparam int ON_MAX = PERIOD_CYC * MAX_PCT / 100;
  localparam int LW     = 17;

  logic [LW-1:0] hi1Len;
  logic [LW-1:0] hi2Len;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hi1Len <= '0;
      hi2Len <= '0;
    end else begin
      hi1Len <= pwmPh1 ? hi1Len + 1'b1 : '0;
      hi2Len <= pwmPh2 ? hi2Len + 1'b1 : '0;
    end
  end

  a_r7_fault_blanks: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> (!pwmPh1 && !pwmPh2));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pwmPh1 && !pwmPh2 && !periodStrobe));

  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> !periodStrobe);

  a_r1_rise_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmPh1) |-> (periodStrobe || $past(faultIn, 2)));

  a_r5_ph1_limit: assert property (@(posedge clk) disable iff (!rstN)
    pwmPh1 |-> (hi1Len < LW'(ON_MAX)));

  a_r5_ph2_limit: assert property (@(posedge clk) disable iff (!rstN)
    pwmPh2 |-> (hi2Len < LW'(ON_MAX)));
endmodule

bind dual_phase_pwm dual_phase_pwm_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .MAX_PCT    (MAX_PCT)
) uChk (.*);

// File: tb/dual_phase_pwm_test.sv
`timescale 1ns/1ps
module dual_phase_pwm_test;
  localparam int P    = 400;
  localparam int HALF = P / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        faultIn = 1'b0;
  logic [15:0] mainDuty = '0;
  logic [15:0] balanceCorr = '0;
  logic        pwmPh1, pwmPh2, periodStrobe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_phase_pwm uut (
    .clk(clk), .rstN(rstN), .enable(enable), .faultIn(faultIn),
    .mainDuty(mainDuty), .balanceCorr(balanceCorr),
    .pwmPh1(pwmPh1), .pwmPh2(pwmPh2), .periodStrobe(periodStrobe)
  );

  // {main, corr, expected phase-1 on-cycles, expected phase-2 on-cycles}
  localparam logic [63:0] VEC [12] = '{
    {16'd16384, 16'd0,     16'd200, 16'd200},
    {16'd16384, 16'd3277,  16'd240, 16'd159},
    {16'd8192,  16'hF000,  16'd50,  16'd150},
    {16'd29491, 16'd2000,  16'd360, 16'd335},
    {16'd3000,  16'd5000,  16'd97,  16'd0},
    {16'd32767, 16'd32767, 16'd360, 16'd0},
    {16'd0,     16'd0,     16'd0,   16'd0},
    {16'd32767, 16'h8000,  16'd0,   16'd360},
    {16'd82,    16'd0,     16'd1,   16'd1},
    {16'd29491, 16'd0,     16'd359, 16'd359},
    {16'd29492, 16'd0,     16'd360, 16'd360},
    {16'd29600, 16'hFF38,  16'd358, 16'd360}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitStrobe();
    @(negedge clk);
    while (!periodStrobe) @(negedge clk);
  endtask

  task automatic measure(output int n1, output int last1, output int n2,
                         output int first2, output int last2,
                         output int strobeMid, output int strobeEnd);
    waitStrobe();
    n1 = 0; last1 = -1; n2 = 0; first2 = -1; last2 = -1;
    strobeMid = 0; strobeEnd = 0;
    for (int k = 0; k < P + HALF; k++) begin
      if (k > 0) @(negedge clk);
      if (k < P && pwmPh1) begin n1++; last1 = k; end
      if (k >= HALF && pwmPh2) begin
        n2++;
        if (first2 < 0) first2 = k;
        last2 = k;
      end
      if (k > 0 && k < P && periodStrobe) strobeMid++;
      if (k == P) strobeEnd = int'(periodStrobe);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n1, last1, n2, first2, last2, sMid, sEnd, cntA, cntB, hits;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset pwmPh1", int'(pwmPh1), 0);
    check("R9 reset pwmPh2", int'(pwmPh2), 0);
    check("R9 reset strobe", int'(periodStrobe), 0);
    rstN = 1'b1;

    // R8: idle while disabled
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hits += int'(pwmPh1) + int'(pwmPh2) + int'(periodStrobe);
    end
    check("R8 idle while disabled", hits, 0);

    // R8: enable start alignment
    mainDuty = 16'd16384; balanceCorr = 16'd0;
    enable = 1'b1;
    @(negedge clk);
    check("R8 first strobe", int'(periodStrobe), 1);
    check("R8 first ph1 pulse", int'(pwmPh1), 1);
    check("R8 ph2 low at enable", int'(pwmPh2), 0);
    hits = 0;
    for (int k = 1; k <= HALF; k++) begin
      @(negedge clk);
      if (k < HALF) hits += int'(pwmPh2);
      else check("R3 ph2 starts at half period", int'(pwmPh2), 1);
    end
    check("R8 ph2 low before own start", hits, 0);

    // R2 R3 R4 R5 R1: vector table
    for (int v = 0; v < 12; v++) begin
      int e1, e2;
      mainDuty    = VEC[v][63:48];
      balanceCorr = VEC[v][47:32];
      e1 = int'(VEC[v][31:16]);
      e2 = int'(VEC[v][15:0]);
      measure(n1, last1, n2, first2, last2, sMid, sEnd);
      check($sformatf("R2 R4 R5 vec%0d ph1 count", v), n1, e1);
      check($sformatf("R2 vec%0d ph1 last", v), last1, e1 - 1);
      check($sformatf("R3 R4 R5 vec%0d ph2 count", v), n2, e2);
      check($sformatf("R3 vec%0d ph2 first", v), first2, (e2 > 0) ? HALF : -1);
      check($sformatf("R3 vec%0d ph2 last", v), last2, (e2 > 0) ? HALF + e2 - 1 : -1);
      check($sformatf("R1 vec%0d strobe mid", v), sMid, 0);
      check($sformatf("R1 vec%0d strobe at period", v), sEnd, 1);
    end

    // R6: mid-period command change
    mainDuty = 16'd16384; balanceCorr = 16'd0;
    measure(n1, last1, n2, first2, last2, sMid, sEnd);
    check("R6 settle count", n1, 200);
    waitStrobe();
    cntA = 0; cntB = 0;
    for (int k = 0; k < 2 * P; k++) begin
      if (k > 0) @(negedge clk);
      if (pwmPh1) begin
        if (k < P) cntA++;
        else cntB++;
      end
      if (k == 50) mainDuty = 16'd8192;
    end
    check("R6 pulse in progress keeps old duty", cntA, 200);
    check("R6 next period takes new duty", cntB, 100);

    // R7: fault blanking with counter still running
    mainDuty = 16'd29491;
    measure(n1, last1, n2, first2, last2, sMid, sEnd);
    check("R7 settle count", n1, 359);
    waitStrobe();
    for (int k = 0; k <= P; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 250) begin
        check("R7 ph1 high before fault", int'(pwmPh1), 1);
        check("R7 ph2 high before fault", int'(pwmPh2), 1);
        faultIn = 1'b1;
      end
      if (k == 251 || k == 255) begin
        check("R7 ph1 blanked", int'(pwmPh1), 0);
        check("R7 ph2 blanked", int'(pwmPh2), 0);
      end
      if (k == 260) faultIn = 1'b0;
      if (k == 261) begin
        check("R7 ph1 resumes", int'(pwmPh1), 1);
        check("R7 ph2 resumes", int'(pwmPh2), 1);
      end
      if (k == P) check("R7 strobe keeps period", int'(periodStrobe), 1);
    end

    // R8: disable stops everything
    enable = 1'b0;
    hits = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      hits += int'(pwmPh1) + int'(pwmPh2) + int'(periodStrobe);
    end
    check("R8 quiet after disable", hits, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule